// File: doc/BRIEF.md
# Multiplexed Address/Data Bus Sequencer

This block turns single transfer requests from a 16-bit core into cycles on an external bus where address and data share the same wires. A request is accepted while the bus is idle. The sequencer then drives the address with the active-low address strobe low for one clock. Next it floats or replaces the address and lowers the active-low data strobe. Last it gives one recovery clock, in which the core sees a one-clock done pulse and, for reads, the captured data.

The data strobe length depends on the cycle type. Memory cycles take one clock, I/O cycles take two, and interrupt-acknowledge cycles take four. Each clock in which the external wait input is high adds one more. Status, direction, width and memory-request indications stay steady for the whole transfer. An external master can ask for the bus. It is granted only between transfers, and while it holds the grant every bus output is released.

Top module: `mux_bus_ctrl`

## Requirements
- R1: During and right after reset: both strobes and the memory request are high, the shared-bus enable is 0, the control enable is 1, bus acknowledge and done are 0, and status is 0.
- R2: On the clock edge after a request is accepted, the address strobe goes low for exactly one clock. In that clock the shared bus drives the request address with its enable at 1, and the data strobe stays high.
- R3: In the data-strobe phase the address strobe is high. A write drives the write data with the bus enable at 1. A read sets the bus enable to 0.
- R4: With wait held low, the data strobe stays low for 1 clock on a memory cycle, 2 clocks on an I/O cycle and 4 clocks on an acknowledge cycle.
- R5: Each data-strobe clock that ends with wait_i high at the rising edge adds one clock to the data-strobe phase.
- R6: Read data is taken from the bus at the edge that raises the data strobe. It stays on rdata_o until the next read completes, and a write leaves it unchanged. done_o is high for exactly the one recovery clock that follows.
- R7: mreq_n_o is low from the address clock through the recovery clock on memory cycles, and stays high on I/O and acknowledge cycles. rd_o (1 = read) and byte_o (1 = byte) hold the request's values over the same span. When idle, rd_o is 1 and byte_o is 0.
- R8: stat_o holds the cycle type from the address clock through the recovery clock, and is 0 otherwise. The codes on cyc_i and stat_o are 1 = memory, 2 = I/O, 3 = acknowledge; a cyc_i of 0 is handled as memory.
- R9: In idle, a high breq_i raises back_o on the next clock, ahead of any core request in the same clock. While back_o is high, ad_oe_o and ctl_oe_o are 0. back_o falls on the clock after breq_i is seen low.
- R10: A bus request that arrives during a transfer does not raise back_o until the transfer ends and the block has spent one clock in idle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| req_i | input | 1 | Core transfer request, sampled in idle |
| addr_i | input | 16 | Transfer address |
| wdata_i | input | 16 | Write data |
| write_i | input | 1 | 1 = write, 0 = read |
| byte_i | input | 1 | 1 = byte transfer |
| cyc_i | input | 2 | Cycle type: 1 memory, 2 I/O, 3 acknowledge |
| rdata_o | output | 16 | Captured read data |
| done_o | output | 1 | One-clock completion pulse |
| ad_i | input | 16 | Shared bus input value |
| ad_o | output | 16 | Shared bus drive value |
| ad_oe_o | output | 1 | Shared bus drive enable |
| as_n_o | output | 1 | Address strobe, active low |
| ds_n_o | output | 1 | Data strobe, active low |
| mreq_n_o | output | 1 | Memory request, active low |
| rd_o | output | 1 | Direction indication, 1 = read |
| byte_o | output | 1 | Width indication, 1 = byte |
| stat_o | output | 2 | Cycle status |
| ctl_oe_o | output | 1 | Enable for strobes and control outputs |
| wait_i | input | 1 | Wait request, stretches the data strobe |
| breq_i | input | 1 | External bus request |
| back_o | output | 1 | Bus acknowledge |

## Verification
The checks take it that wait_i matters only while the data strobe is low, and that breq_i and req_i change only between clock edges. They also take it that the core keeps req_i high for no more than one accepting clock. The stimulus changes every input on the falling clock edge and drops req_i right after the address clock is seen. It raises wait_i only during data-strobe clocks and clears it as soon as the strobe rises.

// File: rtl/mbc_pkg.sv
package mbc_pkg;
  typedef enum logic [2:0] {
    S_IDLE, S_ADDR, S_DATA, S_RECV, S_GRANT
  } state_e;

  localparam logic [1:0] CYC_MEM = 2'd1;
  localparam logic [1:0] CYC_IO  = 2'd2;
  localparam logic [1:0] CYC_ACK = 2'd3;
endpackage

// File: rtl/mbc_fsm.sv
module mbc_fsm
  import mbc_pkg::*;
#(
  parameter int IO_EXTRA  = 1,
  parameter int ACK_EXTRA = 3
) (
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       req_i,
  input  logic       breq_i,
  input  logic       wait_i,
  input  logic [1:0] cyc_q_i,
  output state_e     st_o,
  output logic       accept_o,
  output logic       cap_o
);
  localparam int CW = $clog2(ACK_EXTRA + 2);

  state_e        st_q;
  logic [CW-1:0] cnt_q;
  logic [CW-1:0] extra;

  always_comb begin
    case (cyc_q_i)
      CYC_IO:  extra = CW'(IO_EXTRA);
      CYC_ACK: extra = CW'(ACK_EXTRA);
      default: extra = '0;
    endcase
  end

  assign accept_o = (st_q == S_IDLE) && !breq_i && req_i;
  assign cap_o    = (st_q == S_DATA) && !wait_i && (cnt_q == '0);
  assign st_o     = st_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q  <= S_IDLE;
      cnt_q <= '0;
    end else begin
      case (st_q)
        S_IDLE: begin
          if (breq_i)     st_q <= S_GRANT;
          else if (req_i) st_q <= S_ADDR;
        end
        S_ADDR: begin
          st_q  <= S_DATA;
          cnt_q <= extra;
        end
        S_DATA: begin
          if (!wait_i) begin
            if (cnt_q == '0) st_q <= S_RECV;
            else             cnt_q <= cnt_q - 1'b1;
          end
        end
        S_RECV:  st_q <= S_IDLE;
        S_GRANT: if (!breq_i) st_q <= S_IDLE;
        default: st_q <= S_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/mbc_hold.sv
module mbc_hold
  import mbc_pkg::*;
#(
  parameter int W = 16
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         accept_i,
  input  logic         cap_i,
  input  logic [W-1:0] addr_i,
  input  logic [W-1:0] wdata_i,
  input  logic         write_i,
  input  logic         byte_i,
  input  logic [1:0]   cyc_i,
  input  logic [W-1:0] ad_i,
  output logic [W-1:0] addr_q_o,
  output logic [W-1:0] wdata_q_o,
  output logic         write_q_o,
  output logic         byte_q_o,
  output logic [1:0]   cyc_q_o,
  output logic [W-1:0] rdata_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      addr_q_o  <= '0;
      wdata_q_o <= '0;
      write_q_o <= 1'b0;
      byte_q_o  <= 1'b0;
      cyc_q_o   <= CYC_MEM;
    end else if (accept_i) begin
      addr_q_o  <= addr_i;
      wdata_q_o <= wdata_i;
      write_q_o <= write_i;
      byte_q_o  <= byte_i;
      cyc_q_o   <= (cyc_i == 2'd0) ? CYC_MEM : cyc_i;
    end
  end

  // capture only on reads, at data strobe release
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                 rdata_o <= '0;
    else if (cap_i && !write_q_o) rdata_o <= ad_i;
  end
endmodule

// File: rtl/mbc_pins.sv
module mbc_pins
  import mbc_pkg::*;
#(
  parameter int W = 16
) (
  input  state_e       st_i,
  input  logic [W-1:0] addr_q_i,
  input  logic [W-1:0] wdata_q_i,
  input  logic         write_q_i,
  input  logic         byte_q_i,
  input  logic [1:0]   cyc_q_i,
  output logic [W-1:0] ad_o,
  output logic         ad_oe_o,
  output logic         as_n_o,
  output logic         ds_n_o,
  output logic         mreq_n_o,
  output logic         rd_o,
  output logic         byte_o,
  output logic [1:0]   stat_o,
  output logic         ctl_oe_o,
  output logic         back_o,
  output logic         done_o
);
  logic busy;
  assign busy = (st_i == S_ADDR) || (st_i == S_DATA) || (st_i == S_RECV);

  assign as_n_o   = (st_i != S_ADDR);
  assign ds_n_o   = (st_i != S_DATA);
  assign ad_oe_o  = (st_i == S_ADDR) || ((st_i == S_DATA) && write_q_i);
  assign ad_o     = (st_i == S_ADDR) ? addr_q_i : wdata_q_i;
  assign mreq_n_o = !(busy && (cyc_q_i == CYC_MEM));
  assign rd_o     = busy ? !write_q_i : 1'b1;
  assign byte_o   = busy && byte_q_i;
  assign stat_o   = busy ? cyc_q_i : 2'd0;
  assign ctl_oe_o = (st_i != S_GRANT);
  assign back_o   = (st_i == S_GRANT);
  assign done_o   = (st_i == S_RECV);
endmodule

// File: rtl/mux_bus_ctrl.sv
module mux_bus_ctrl
  import mbc_pkg::*;
#(
  parameter int W         = 16,
  parameter int IO_EXTRA  = 1,
  parameter int ACK_EXTRA = 3
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         req_i,
  input  logic [W-1:0] addr_i,
  input  logic [W-1:0] wdata_i,
  input  logic         write_i,
  input  logic         byte_i,
  input  logic [1:0]   cyc_i,
  output logic [W-1:0] rdata_o,
  output logic         done_o,
  input  logic [W-1:0] ad_i,
  output logic [W-1:0] ad_o,
  output logic         ad_oe_o,
  output logic         as_n_o,
  output logic         ds_n_o,
  output logic         mreq_n_o,
  output logic         rd_o,
  output logic         byte_o,
  output logic [1:0]   stat_o,
  output logic         ctl_oe_o,
  input  logic         wait_i,
  input  logic         breq_i,
  output logic         back_o
);
  state_e       st;
  logic         accept, cap;
  logic [W-1:0] addr_q, wdata_q;
  logic         write_q, byte_q;
  logic [1:0]   cyc_q;

  mbc_fsm #(.IO_EXTRA(IO_EXTRA), .ACK_EXTRA(ACK_EXTRA)) u_fsm (
    .clk_i, .rst_ni, .req_i, .breq_i, .wait_i,
    .cyc_q_i(cyc_q), .st_o(st), .accept_o(accept), .cap_o(cap)
  );

  mbc_hold #(.W(W)) u_hold (
    .clk_i, .rst_ni, .accept_i(accept), .cap_i(cap),
    .addr_i, .wdata_i, .write_i, .byte_i, .cyc_i, .ad_i,
    .addr_q_o(addr_q), .wdata_q_o(wdata_q), .write_q_o(write_q),
    .byte_q_o(byte_q), .cyc_q_o(cyc_q), .rdata_o
  );

  mbc_pins #(.W(W)) u_pins (
    .st_i(st), .addr_q_i(addr_q), .wdata_q_i(wdata_q), .write_q_i(write_q),
    .byte_q_i(byte_q), .cyc_q_i(cyc_q), .ad_o, .ad_oe_o, .as_n_o, .ds_n_o,
    .mreq_n_o, .rd_o, .byte_o, .stat_o, .ctl_oe_o, .back_o, .done_o
  );
endmodule

// File: rtl/mbc_chk.sv
module mbc_chk (
  input logic       clk_i,
  input logic       rst_ni,
  input logic       as_n_o,
  input logic       ds_n_o,
  input logic       ad_oe_o,
  input logic       ctl_oe_o,
  input logic       back_o,
  input logic       done_o,
  input logic       rd_o,
  input logic       wait_i,
  input logic [1:0] stat_o
);
  a_r2_strobes_apart: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(!as_n_o && !ds_n_o));

  a_r3_ds_after_as: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(ds_n_o) |-> as_n_o && !$past(as_n_o));

  a_r5_wait_stretch: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!ds_n_o && wait_i) |=> !ds_n_o);

  a_r6_done_follows_ds: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(ds_n_o) |-> done_o);

  a_r6_done_single: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |=> !done_o);

  a_r7_rd_steady: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !as_n_o |=> $stable(rd_o));

  a_r8_stat_valid: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!as_n_o || !ds_n_o || done_o) |-> stat_o != 2'd0);

  a_r9_grant_floats: assert property (@(posedge clk_i) disable iff (!rst_ni)
    back_o |-> !ad_oe_o && !ctl_oe_o);

  a_r10_grant_idle: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(back_o) |-> $past(stat_o) == 2'd0);
endmodule

bind mux_bus_ctrl mbc_chk u_chk (
  .clk_i, .rst_ni, .as_n_o, .ds_n_o, .ad_oe_o, .ctl_oe_o,
  .back_o, .done_o, .rd_o, .wait_i, .stat_o
);

// File: tb/mux_bus_ctrl_test.sv
module mux_bus_ctrl_test;
  localparam int CLK_P = 10;

  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic        req_i = 1'b0, write_i = 1'b0, byte_i = 1'b0;
  logic [15:0] addr_i = '0, wdata_i = '0, ad_i = '0;
  logic [1:0]  cyc_i = 2'd1;
  logic        wait_i = 1'b0, breq_i = 1'b0;
  logic [15:0] rdata_o, ad_o;
  logic        done_o, ad_oe_o, as_n_o, ds_n_o, mreq_n_o, rd_o, byte_o;
  logic        ctl_oe_o, back_o;
  logic [1:0]  stat_o;

  int n_chk = 0, n_bad = 0, cyc_cnt = 0;
  logic [15:0] last_rd = '0;

  always #(CLK_P/2) clk_i = ~clk_i;

  mux_bus_ctrl uut (.*);

  task automatic chk(string tag, logic [31:0] act, logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
    end
  endtask

  task automatic t_reset();
    #1;
    chk("R1 as_n", as_n_o, 1);       chk("R1 ds_n", ds_n_o, 1);
    chk("R1 mreq_n", mreq_n_o, 1);   chk("R1 ad_oe", ad_oe_o, 0);
    chk("R1 ctl_oe", ctl_oe_o, 1);   chk("R1 back", back_o, 0);
    chk("R1 done", done_o, 0);       chk("R1 stat", stat_o, 0);
    @(negedge clk_i); rst_ni = 1'b1;
    @(negedge clk_i);
    chk("R1 after reset stat", stat_o, 0);
  endtask

  task automatic t_cycle(logic [1:0] cyc, logic wr, logic by,
                         logic [15:0] a, logic [15:0] d, int nw);
    int n = 0, left = nw, base;
    logic [15:0] rv = d ^ 16'h5a5a;
    base = (cyc == 2'd2) ? 2 : (cyc == 2'd3) ? 4 : 1;
    @(negedge clk_i);
    req_i = 1; cyc_i = cyc; write_i = wr; byte_i = by;
    addr_i = a; wdata_i = d; ad_i = rv;
    @(negedge clk_i);
    req_i = 0;
    chk("R2 as_n low", as_n_o, 0);   chk("R2 addr", ad_o, a);
    chk("R2 oe", ad_oe_o, 1);        chk("R2 ds_n high", ds_n_o, 1);
    chk("R8 stat addr", stat_o, cyc);
    chk("R7 mreq", mreq_n_o, cyc != 2'd1);
    chk("R7 rd", rd_o, !wr);         chk("R7 byte", byte_o, by);
    @(negedge clk_i);
    while (ds_n_o == 1'b0 && n < 40) begin
      chk("R3 as_n high", as_n_o, 1);
      chk("R3 oe", ad_oe_o, wr);
      if (wr) chk("R3 wdata", ad_o, d);
      chk("R7 mreq data", mreq_n_o, cyc != 2'd1);
      chk("R7 rd data", rd_o, !wr);
      n++;
      wait_i = (left > 0);
      if (left > 0) left--;
      @(negedge clk_i);
    end
    wait_i = 0;
    if (nw > 0) chk("R5 ds length", n, base + nw);
    else        chk("R4 ds length", n, base);
    chk("R6 done", done_o, 1);
    if (!wr) last_rd = rv;
    chk("R6 rdata", rdata_o, last_rd);
    chk("R8 stat recovery", stat_o, cyc);
    chk("R7 mreq recovery", mreq_n_o, cyc != 2'd1);
    @(negedge clk_i);
    chk("R6 done single", done_o, 0);
    chk("R8 stat idle", stat_o, 0);
    chk("R7 mreq idle", mreq_n_o, 1);
    chk("R7 rd idle", rd_o, 1);
    chk("R6 rdata held", rdata_o, last_rd);
  endtask

  task automatic t_grant_contend();
    @(negedge clk_i);
    breq_i = 1; req_i = 1; cyc_i = 2'd1; write_i = 1; addr_i = 16'h0042;
    @(negedge clk_i);
    chk("R9 back", back_o, 1);       chk("R9 ad_oe", ad_oe_o, 0);
    chk("R9 ctl_oe", ctl_oe_o, 0);   chk("R9 no address", as_n_o, 1);
    repeat (2) @(negedge clk_i);
    chk("R9 back held", back_o, 1);
    breq_i = 0;
    @(negedge clk_i);
    chk("R9 back released", back_o, 0);
    chk("R9 ctl_oe back", ctl_oe_o, 1);
    @(negedge clk_i);
    req_i = 0;
    chk("R9 core after grant", as_n_o, 0);
    chk("R9 core address", ad_o, 16'h0042);
    repeat (3) @(negedge clk_i);
    chk("R9 core cycle ended", stat_o, 0);
  endtask

  task automatic t_grant_defer();
    @(negedge clk_i);
    req_i = 1; cyc_i = 2'd2; write_i = 0; addr_i = 16'h0300;
    @(negedge clk_i);
    req_i = 0; breq_i = 1;
    chk("R10 address phase", as_n_o, 0);
    for (int i = 0; i < 3; i++) begin
      @(negedge clk_i);
      chk("R10 back held off", back_o, 0);
    end
    chk("R10 recovery", done_o, 1);
    @(negedge clk_i);
    chk("R10 idle clock", back_o, 0);
    @(negedge clk_i);
    chk("R10 granted", back_o, 1);
    breq_i = 0;
    @(negedge clk_i);
    chk("R10 released", back_o, 0);
  endtask

  initial begin
    t_reset();
    t_cycle(2'd1, 1'b0, 1'b0, 16'h1234, 16'h00a5, 0);
    t_cycle(2'd1, 1'b1, 1'b1, 16'h2000, 16'hbeef, 0);
    t_cycle(2'd2, 1'b0, 1'b1, 16'h0080, 16'h0f0f, 0);
    t_cycle(2'd3, 1'b0, 1'b0, 16'hfff0, 16'h7777, 0);
    t_cycle(2'd1, 1'b0, 1'b0, 16'h4000, 16'h1111, 2);
    t_cycle(2'd2, 1'b1, 1'b0, 16'h0090, 16'hcafe, 1);
    t_cycle(2'd3, 1'b0, 1'b1, 16'h0001, 16'h3c3c, 3);
    t_grant_contend();
    t_grant_defer();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  always @(posedge clk_i) begin
    cyc_cnt++;
    if (cyc_cnt > 20000) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog: actual %0d expected below 20000 cycles", cyc_cnt);
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end
endmodule